// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache

This block sits between a processor's load/store port and a block-wide backing memory. It accepts one word request at a time and splits the word address into three fields: a word-within-block select, a set index and a tag. The selected set holds two ways. Both stored tags are compared with the request tag at once. A valid way whose tag matches serves the request directly. When neither way matches, the whole block is fetched from memory. It is installed in an empty way when the set still has one. Otherwise it replaces the way that was used less recently, as recorded by a single bit per set.

Writes are write-through with allocation. A write that hits updates the cached word. A write that misses first brings the block in and merges the new word. In both cases the word is also sent to memory in the response cycle. Every access ends with a one-cycle response that reports hit or miss, the way that was used and the word.

Top module: `cache2w_top`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, mem_rd_req and mem_wr_req are 0. Every way of every set is empty, so the first access to any address misses.
- R2: A request whose block is resident in either way of its set gives resp_valid=1 with resp_hit=1 exactly one clock after the edge that accepted it. mem_rd_req is not raised for that request.
- R3: A miss raises mem_rd_req, with mem_rd_addr equal to the request address rounded down to a multiple of BLOCK_WORDS. Both are held until mem_rd_valid is sampled high. The response with resp_hit=0 appears one clock after that edge.
- R4: On a miss in a set with an empty way, the block goes into the lowest-numbered empty way, and that number is reported on resp_way (way 0 before way 1).
- R5: On a miss in a set whose two ways are both valid, the way replaced is the one not touched most recently. A hit or a fill by either a read or a write counts as a touch.
- R6: resp_rdata of a read returns the last value written to that word address through the cache, or the memory word when it was never written. resp_rdata of a write returns the written word.
- R7: Each write, hit or miss, produces exactly one mem_wr_req pulse in the same cycle as its resp_valid, carrying the request's word address and data. Reads never raise mem_wr_req.
- R8: A write miss installs the fetched block with the written word merged in. A later read of the same address hits and returns the written data.
- R9: req_ready is low from the accepting edge until the response cycle. resp_valid never stays high for two cycles in a row.
- R10: The set index is (addr / BLOCK_WORDS) mod SETS and the tag is addr / (BLOCK_WORDS*SETS). Two blocks with the same index and different tags can be resident at the same time, one in each way, and an access to another set disturbs neither of them.
- R11: With the default parameters (2 sets, one-word blocks) and starting from reset, the word address sequence 0,2,0,1,4,0,2,3,5,4 gives these results. Hit pattern: miss,miss,hit,miss,miss,hit,miss,miss,miss,miss. Ways reported: 0,1,0,0,1,0,1,1,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The cache is idle and will accept a request at the next edge |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Word to write |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 when the request hit, 0 when it needed a refill |
| resp_way | output | 1 | Way that served or received the block |
| resp_rdata | output | DATA_W | Word read, or the word written |
| mem_rd_req | output | 1 | Block fetch request, held until mem_rd_valid |
| mem_rd_addr | output | ADDR_W | Word address of the first word of the block to fetch |
| mem_rd_valid | input | 1 | Fetched block is present on mem_rd_data |
| mem_rd_data | input | BLOCK_WORDS*DATA_W | Fetched block, word 0 in the low bits |
| mem_wr_req | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Word address to write in memory |
| mem_wr_data | output | DATA_W | Word to write in memory |

## Verification
A stale or flipped replacement bit does not show up until the next conflict miss in that set. At that point resp_way names the wrong way, and one access later a block that should still be resident misses, which is visible as an unexpected mem_rd_req. A lost or spurious valid bit shows on the very next access to the block: resp_hit is wrong, and a fetch starts, or fails to start, in the cycle after the lookup. A corrupted data store shows only when the word is next read, on resp_rdata. So the bench mixes rereads of recently written words with dense traffic over few addresses, so that each of these faults is exposed within a few accesses of being caused.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } cache_state_e;
endpackage

// File: rtl/cache2w_tag_match.sv
module cache2w_tag_match
  import cache2w_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [NUM_WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]               look_tag,
  output logic                           any_hit,
  output logic                           hit_way
);
  logic [NUM_WAYS-1:0] way_match;

  // one comparator per way, all working in parallel
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign way_match[w] = way_valid[w] && (way_tag[w] == look_tag);
  end

  assign any_hit = |way_match;
  // a block is never resident twice in one set, so way 1 matching alone names it
  assign hit_way = way_match[1];
endmodule

// File: rtl/cache2w_victim_sel.sv
module cache2w_victim_sel
  import cache2w_pkg::*;
(
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic                lru_way,
  output logic                victim_way
);
  always_comb begin
    if (!way_valid[0])      victim_way = 1'b0;
    else if (!way_valid[1]) victim_way = 1'b1;
    else                    victim_way = lru_way;
  end
endmodule

// File: rtl/cache2w_store.sv
module cache2w_store
  import cache2w_pkg::*;
#(
  parameter int SETS  = 2,
  parameter int IDX_W = 1,
  parameter int TAG_W = 7,
  parameter int BLK_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [IDX_W-1:0]               acc_set,
  output logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag,
  output logic [NUM_WAYS-1:0]            rd_valid,
  output logic [NUM_WAYS-1:0][BLK_W-1:0] rd_block,
  output logic                           rd_lru,
  input  logic                           wr_en,
  input  logic                           wr_way,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic [BLK_W-1:0]               wr_block,
  input  logic                           touch_en,
  input  logic                           touch_way
);
  // lru_q[s] names the way to evict next in set s
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_r [SETS];
    logic [BLK_W-1:0] blk_r [SETS];
    logic [SETS-1:0]  vld_r;
    logic             sel_w;

    assign sel_w = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_r <= '0;
      else if (sel_w) vld_r[acc_set] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel_w) begin
        tag_r[acc_set] <= wr_tag;
        blk_r[acc_set] <= wr_block;
      end
    end

    assign rd_tag[w]   = tag_r[acc_set];
    assign rd_block[w] = blk_r[acc_set];
    assign rd_valid[w] = vld_r[acc_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q <= '0;
    else if (touch_en) lru_q[acc_set] <= ~touch_way;
  end

  assign rd_lru = lru_q[acc_set];
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SETS        = 2,
  parameter int BLOCK_WORDS = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          resp_valid,
  output logic                          resp_hit,
  output logic                          resp_way,
  output logic [DATA_W-1:0]             resp_rdata,
  output logic                          mem_rd_req,
  output logic [ADDR_W-1:0]             mem_rd_addr,
  input  logic                          mem_rd_valid,
  input  logic [BLOCK_WORDS*DATA_W-1:0] mem_rd_data,
  output logic                          mem_wr_req,
  output logic [ADDR_W-1:0]             mem_wr_addr,
  output logic [DATA_W-1:0]             mem_wr_data
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WSEL_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
  localparam int TAG_W  = ADDR_W - $clog2(SETS * BLOCK_WORDS);
  localparam int BLK_W  = BLOCK_WORDS * DATA_W;

  // ---------------- address arithmetic ----------------
  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return IDX_W'((a / ADDR_W'(BLOCK_WORDS)) % ADDR_W'(SETS));
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return TAG_W'(a / ADDR_W'(SETS * BLOCK_WORDS));
  endfunction

  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return WSEL_W'(a % ADDR_W'(BLOCK_WORDS));
  endfunction

  function automatic logic [ADDR_W-1:0] block_base(input logic [ADDR_W-1:0] a);
    return a - (a % ADDR_W'(BLOCK_WORDS));
  endfunction

  function automatic logic [DATA_W-1:0] get_word(input logic [BLK_W-1:0] blk,
                                                  input logic [WSEL_W-1:0] w);
    return blk[int'(w)*DATA_W +: DATA_W];
  endfunction

  function automatic logic [BLK_W-1:0] put_word(input logic [BLK_W-1:0] blk,
                                                 input logic [WSEL_W-1:0] w,
                                                 input logic [DATA_W-1:0] d);
    logic [BLK_W-1:0] r;
    r = blk;
    r[int'(w)*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  // ---------------- request capture ----------------
  cache_state_e        state_q;
  logic                req_write_q;
  logic [ADDR_W-1:0]   req_addr_q;
  logic [DATA_W-1:0]   req_wdata_q;

  logic [IDX_W-1:0]    cur_set;
  logic [TAG_W-1:0]    cur_tag;
  logic [WSEL_W-1:0]   cur_word;

  assign cur_set  = set_of(req_addr_q);
  assign cur_tag  = tag_of(req_addr_q);
  assign cur_word = word_of(req_addr_q);

  // ---------------- storage and lookup ----------------
  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [NUM_WAYS-1:0]            rd_valid;
  logic [NUM_WAYS-1:0][BLK_W-1:0] rd_block;
  logic                           rd_lru;
  logic                           any_hit;
  logic                           hit_way;
  logic                           victim_way;

  // named internal events
  logic             lookup_hit;
  logic             lookup_miss;
  logic             fill_en;
  logic             hit_write_en;
  logic             wr_en;
  logic             wr_way;
  logic [BLK_W-1:0] wr_block;
  logic [BLK_W-1:0] hit_block;
  logic [BLK_W-1:0] resp_block;
  logic             touch_en;
  logic             touch_way;

  cache2w_store #(
    .SETS (SETS),
    .IDX_W(IDX_W),
    .TAG_W(TAG_W),
    .BLK_W(BLK_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_set  (cur_set),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .rd_block (rd_block),
    .rd_lru   (rd_lru),
    .wr_en    (wr_en),
    .wr_way   (wr_way),
    .wr_tag   (cur_tag),
    .wr_block (wr_block),
    .touch_en (touch_en),
    .touch_way(touch_way)
  );

  cache2w_tag_match #(
    .TAG_W(TAG_W)
  ) u_match (
    .way_tag  (rd_tag),
    .way_valid(rd_valid),
    .look_tag (cur_tag),
    .any_hit  (any_hit),
    .hit_way  (hit_way)
  );

  cache2w_victim_sel u_victim (
    .way_valid (rd_valid),
    .lru_way   (rd_lru),
    .victim_way(victim_way)
  );

  assign lookup_hit   = (state_q == ST_LOOKUP) && any_hit;
  assign lookup_miss  = (state_q == ST_LOOKUP) && !any_hit;
  assign fill_en      = (state_q == ST_FILL) && mem_rd_valid;
  assign hit_write_en = lookup_hit && req_write_q;

  assign hit_block = rd_block[hit_way];
  assign wr_en     = fill_en || hit_write_en;
  assign wr_way    = fill_en ? victim_way : hit_way;

  always_comb begin
    if (fill_en) begin
      wr_block = req_write_q ? put_word(mem_rd_data, cur_word, req_wdata_q) : mem_rd_data;
    end else begin
      wr_block = put_word(hit_block, cur_word, req_wdata_q);
    end
  end

  assign resp_block = wr_en ? wr_block : hit_block;
  assign touch_en   = lookup_hit || fill_en;
  assign touch_way  = fill_en ? victim_way : hit_way;

  // ---------------- control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_write_q <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q     <= ST_LOOKUP;
            req_write_q <= req_write;
            req_addr_q  <= req_addr;
            req_wdata_q <= req_wdata;
          end
        end
        ST_LOOKUP: state_q <= lookup_miss ? ST_FILL : ST_IDLE;
        ST_FILL:   if (mem_rd_valid) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- response and write-through ----------------
  logic              resp_valid_q;
  logic              resp_hit_q;
  logic              resp_way_q;
  logic [DATA_W-1:0] resp_rdata_q;
  logic              mem_wr_req_q;
  logic [ADDR_W-1:0] mem_wr_addr_q;
  logic [DATA_W-1:0] mem_wr_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q  <= 1'b0;
      resp_hit_q    <= 1'b0;
      resp_way_q    <= 1'b0;
      resp_rdata_q  <= '0;
      mem_wr_req_q  <= 1'b0;
      mem_wr_addr_q <= '0;
      mem_wr_data_q <= '0;
    end else begin
      resp_valid_q <= touch_en;
      mem_wr_req_q <= touch_en && req_write_q;
      if (touch_en) begin
        resp_hit_q    <= lookup_hit;
        resp_way_q    <= touch_way;
        resp_rdata_q  <= get_word(resp_block, cur_word);
        mem_wr_addr_q <= req_addr_q;
        mem_wr_data_q <= req_wdata_q;
      end
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign resp_valid  = resp_valid_q;
  assign resp_hit    = resp_hit_q;
  assign resp_way    = resp_way_q;
  assign resp_rdata  = resp_rdata_q;
  assign mem_rd_req  = (state_q == ST_FILL);
  assign mem_rd_addr = block_base(req_addr_q);
  assign mem_wr_req  = mem_wr_req_q;
  assign mem_wr_addr = mem_wr_addr_q;
  assign mem_wr_data = mem_wr_data_q;
endmodule

// File: rtl/cache2w_checker.sv
module cache2w_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_req,
  input logic              fill_en,
  input logic              fill_way,
  input logic [1:0]        set_valid,
  input logic              set_lru
);
  assert_resp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_fetch_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

  assert_miss_follows_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> $past(mem_rd_req && mem_rd_valid));

  assert_hit_without_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> !$past(mem_rd_req));

  assert_write_with_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> resp_valid);

  assert_way0_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !set_valid[0] |-> !fill_way);

  assert_way1_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && set_valid[0] && !set_valid[1] |-> fill_way);

  assert_lru_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && (&set_valid) |-> fill_way == set_lru);
endmodule

bind cache2w_top cache2w_checker #(
  .ADDR_W(ADDR_W)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_req  (mem_wr_req),
  .fill_en     (fill_en),
  .fill_way    (victim_way),
  .set_valid   (rd_valid),
  .set_lru     (rd_lru)
);

// File: tb/cache2w_top_test.sv
module cache2w_top_test;
  localparam int AW   = 8;
  localparam int DW   = 32;
  localparam int NSET = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          resp_valid;
  logic          resp_hit;
  logic          resp_way;
  logic [DW-1:0] resp_rdata;
  logic          mem_rd_req;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rd_valid = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic          mem_wr_req;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  cache2w_top #(.ADDR_W(AW), .DATA_W(DW), .SETS(NSET), .BLOCK_WORDS(1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .resp_rdata(resp_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  // backing memory and reference cache state
  logic [DW-1:0] mem [1 << AW];
  bit            ref_vld [2][NSET];
  int            ref_tag [2][NSET];
  bit            ref_lru [NSET];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_set(input int a);
    return a % NSET;
  endfunction

  function automatic int ref_tagv(input int a);
    return a / NSET;
  endfunction

  task automatic access(input bit wr, input int addr, input logic [DW-1:0] wd,
                        output bit got_hit, output bit got_way);
    int s, t, wait_n, guard;
    bit exp_hit, exp_way, fetched, from_empty;
    logic [DW-1:0] exp_data;
    s = ref_set(addr);
    t = ref_tagv(addr);
    exp_hit = 0; exp_way = 0; from_empty = 0;
    for (int w = 0; w < 2; w++)
      if (ref_vld[w][s] && ref_tag[w][s] == t) begin exp_hit = 1; exp_way = w[0]; end
    if (!exp_hit) begin
      if (!ref_vld[0][s])      begin exp_way = 0; from_empty = 1; end
      else if (!ref_vld[1][s]) begin exp_way = 1; from_empty = 1; end
      else                     exp_way = ref_lru[s];
    end
    exp_data = wr ? wd : mem[addr];

    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R9", "ready low while busy", 32'(req_ready), 0);
    fetched = 0; wait_n = 0; guard = 0;
    while (!resp_valid) begin
      if (mem_rd_req) begin
        if (!fetched) begin
          fetched = 1;
          chk(mem_rd_addr == AW'(addr), "R3", "fetch address", 32'(mem_rd_addr), 32'(addr));
          wait_n = $urandom_range(0, 3);
        end
        if (wait_n == 0) begin
          mem_rd_valid = 1;
          mem_rd_data  = mem[addr];
        end else wait_n--;
      end
      @(negedge clk);
      mem_rd_valid = 0;
      guard++;
      if (guard > 40) begin
        chk(0, "R3", "response timeout", 0, 1);
        break;
      end
    end
    got_hit = resp_hit;
    got_way = resp_way;
    chk(resp_hit == exp_hit, "R2", "hit flag", 32'(resp_hit), 32'(exp_hit));
    chk(fetched == !exp_hit, "R3", "fetch issued", 32'(fetched), 32'(!exp_hit));
    chk(resp_way == exp_way, (exp_hit || from_empty) ? "R4" : "R5", "way",
        32'(resp_way), 32'(exp_way));
    chk(resp_rdata == exp_data, "R6", "data", resp_rdata, exp_data);
    chk(mem_wr_req == wr, "R7", "write-through strobe", 32'(mem_wr_req), 32'(wr));
    if (wr) begin
      chk(mem_wr_addr == AW'(addr), "R7", "write-through address", 32'(mem_wr_addr), 32'(addr));
      chk(mem_wr_data == wd, "R7", "write-through data", mem_wr_data, wd);
      mem[addr] = wd;
    end
    ref_vld[exp_way][s] = 1;
    ref_tag[exp_way][s] = t;
    ref_lru[s] = !exp_way;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit h, w;
    int exp_ways [10] = '{0, 1, 0, 0, 1, 0, 1, 1, 0, 0};
    int seq      [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
    bit exp_hits [10] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
    for (int i = 0; i < NSET; i++) begin
      ref_vld[0][i] = 0; ref_vld[1][i] = 0; ref_lru[i] = 0;
    end

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 0);
    chk(mem_rd_req == 1'b0, "R1", "mem_rd_req after reset", 32'(mem_rd_req), 0);
    chk(mem_wr_req == 1'b0, "R1", "mem_wr_req after reset", 32'(mem_wr_req), 0);

    // R11: worked replacement sequence from a fresh cache (first access also covers R1)
    for (int i = 0; i < 10; i++) begin
      access(0, seq[i], '0, h, w);
      chk(h == exp_hits[i], "R11", $sformatf("hit at step %0d", i), 32'(h), 32'(exp_hits[i]));
      chk(w == exp_ways[i][0], "R11", $sformatf("way at step %0d", i), 32'(w), 32'(exp_ways[i]));
    end

    // R10: two tags in one set coexist, the other set leaves them alone
    access(0, 6, '0, h, w);
    access(0, 8, '0, h, w);
    access(0, 6, '0, h, w);
    chk(h == 1'b1, "R10", "6 kept beside 8", 32'(h), 1);
    access(0, 7, '0, h, w);
    access(0, 8, '0, h, w);
    chk(h == 1'b1, "R10", "8 kept after set 1 access", 32'(h), 1);

    // R8: write miss allocates, read back hits with the new word
    access(1, 200, 32'hCAFE_0001, h, w);
    chk(h == 1'b0, "R8", "write miss", 32'(h), 0);
    access(0, 200, '0, h, w);
    chk(h == 1'b1, "R8", "read after write miss hits", 32'(h), 1);
    // R5: a write hit counts as a touch
    access(1, 6, 32'h1234_5678, h, w);
    access(0, 8, '0, h, w);
    access(1, 8, 32'h0BAD_F00D, h, w);
    access(0, 10, '0, h, w);
    access(0, 6, '0, h, w);

    // constrained random traffic over a narrow address window
    for (int i = 0; i < 400; i++) begin
      access(($urandom % 100) < 40, $urandom_range(0, 11), $urandom, h, w);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule